// File: doc/BRIEF.md
# Second-Order Delta-Sigma Bitstream Modulator

This block is a fully digital second-order delta-sigma modulator. It turns a held signed 16-bit sample into a one-bit stream whose ones density is proportional to the sample. It also produces a bit clock, derived by dividing the system clock, that frames the stream. It serves as a synthesizable stand-in for an isolated shunt-sensing modulator. The sample codes +32767 and -32767 stand for +320 mV and -320 mV. The code 0.78125 of full scale, which is 25600, stands for 250 mV.

The loop has two integrators in cascade, a one-bit quantizer, and feedback of plus or minus full scale into both integrators. The sample is clipped to a symmetric range. Both integrators saturate at fixed limits, so a full-scale input cannot wrap them. A downstream decimation filter reads the bit on each falling edge of the bit clock. The bit changes only on the rising edge.

Top module: `dsm2_bitstream`

## Requirements
- R1: With a zero sample held from reset, the stream is exactly 1,0,1,0,... and the first bit is 1.
- R2: Samples of +25600 and -25600 give ones densities of 89.06% and 10.94%, each within ±0.2% over a 4096-bit window.
- R3: Once settled, +32767 gives all ones. Both -32767 and -32768 give all zeros, because -32768 is clipped to -32767.
- R4: For any sample c with |c| ≤ 28000, the ones density over 4096 bits is (1 + c/32767)/2 within ±0.2%.
- R5: The data output changes only on a rising edge of the bit clock. It holds the same value at the following falling edge.
- R6: The bit clock is the system clock divided by 2·HALF_DIV, with HALF_DIV system cycles high and HALF_DIV system cycles low.
- R7: During reset the data output and the bit clock are low. The first bit appears on the first rising edge of the bit clock after reset is released.
- R8: The sample is used only at rising edges of the bit clock. Changes between those edges have no effect on the stream.
- R9: After a long run at full scale, the saturated integrators recover, and a later zero sample again gives a 50% density within ±0.2%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | 16 | Signed input sample, held between updates |
| bclk | output | 1 | Bit clock, system clock divided by 2·HALF_DIV |
| dout | output | 1 | Modulator bit, updated on the bit clock rising edge |

## Verification
A held zero checks that the loop locks into exact alternation. The ±0.78125 full-scale codes measure the density at the specified performance points. Positive full scale, negative full scale and the most negative code separate correct saturation and clipping from wraparound. Random mid-range codes from a fixed seed confirm that density tracks the input linearly. A zero that follows full scale shows that the integrators recover from their limits. Pulses on the sample between bit clock edges must leave the alternating stream unchanged.

// File: rtl/dsm2_bitstream.sv
module dsm2_bitstream #(
  parameter int SAMPLE_W = 16,
  parameter int HALF_DIV = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic                       bclk,
  output logic                       dout
);
  localparam int ACC_W  = SAMPLE_W + 10;
  localparam int CW     = $clog2(HALF_DIV) + 1;
  localparam int FS_I   = 2**(SAMPLE_W-1) - 1;
  localparam logic signed [ACC_W-1:0] FS     = ACC_W'(FS_I);
  localparam logic signed [ACC_W-1:0] FB     = ACC_W'(2*FS_I);
  localparam logic signed [ACC_W-1:0] I1_LIM = ACC_W'(16*2*FS_I);
  localparam logic signed [ACC_W-1:0] I2_LIM = ACC_W'(32*2*FS_I);
  localparam logic signed [SAMPLE_W-1:0] SMIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [CW-1:0] cnt;
  logic signed [ACC_W-1:0] i1, i2, x_in, x2, fb, i1_sum, i2_sum;
  logic tick, quant;

  function automatic logic signed [ACC_W-1:0] sat(input logic signed [ACC_W-1:0] v,
                                                  input logic signed [ACC_W-1:0] lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // bit clock divider; tick marks the system edge that raises bclk
  assign tick = (cnt == CW'(HALF_DIV-1)) && !bclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (cnt == CW'(HALF_DIV-1)) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // symmetric clip, then scale by two so half of full scale is an integer
  assign x_in   = (sample == SMIN) ? -FS : ACC_W'(sample);
  assign x2     = x_in <<< 1;
  assign quant  = ~i2[ACC_W-1];
  assign fb     = quant ? FB : -FB;
  assign i1_sum = i1 + x2 - fb;
  assign i2_sum = i2 + i1 - fb;

  always_ff @(posedge clk) begin
    if (rst) begin
      i1   <= FS;
      i2   <= '0;
      dout <= 1'b0;
    end else if (tick) begin
      dout <= quant;
      i1   <= sat(i1_sum, I1_LIM);
      i2   <= sat(i2_sum, I2_LIM);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!dout && !bclk && i2 == '0)); // R7
  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> $rose(bclk)); // R5
  AST_BCLK_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(bclk) |-> ($past(cnt) == CW'(HALF_DIV-1))); // R6
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(i1) && $stable(i2))); // R8
endmodule

// File: tb/dsm2_bitstream_test.sv
module dsm2_bitstream_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 1;
  localparam int WIN   = 4096;
  localparam int SKIP  = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [15:0] sample = '0;
  logic bclk, dout;
  int errs = 0;
  int checks = 0;

  dsm2_bitstream #(.SAMPLE_W(16), .HALF_DIV(HALF)) uut (
    .clk(clk), .rst(rst), .sample(sample), .bclk(bclk), .dout(dout));

  always #(CLK_P/2) clk = ~clk;

  function automatic real exp_ones(input int c);
    int cc = (c < -32767) ? -32767 : c;
    return WIN * (1.0 + cc / 32767.0) / 2.0;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic get_bit(output logic b, output logic steady);
    logic r;
    @(posedge bclk); #1 r = dout;
    @(negedge bclk); #1 b = dout;
    steady = (r == b);
  endtask

  task automatic density(input int c, input string req, input bit exact);
    logic b, s;
    int ones = 0, unsteady = 0;
    real e, d;
    @(negedge clk) sample = 16'(c);
    for (int k = 0; k < SKIP; k++) get_bit(b, s);
    for (int k = 0; k < WIN; k++) begin
      get_bit(b, s);
      if (b) ones++;
      if (!s) unsteady++;
    end
    e = exp_ones(c);
    d = ones - e;
    if (d < 0) d = -d;
    if (exact) check(d < 0.5, req, $sformatf("ones for code %0d", c), ones, e);
    else check(d <= 8.2, req, $sformatf("ones for code %0d", c), ones, e);
    check(unsteady == 0, "R5", "bits changed before falling edge", unsteady, 0);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1; sample = '0;
    repeat (3) @(negedge clk);
    check(dout == 1'b0 && bclk == 1'b0, "R7", "outputs low in reset", {dout, bclk}, 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic b, s;
    int bad;
    time t0, t1, t2;
    void'($urandom(32'd4711));

    do_reset();
    // R7: first bit on first rising edge; low until then
    @(posedge bclk); #1;
    check(dout == 1'b1, "R7", "first bit after reset", dout, 1);
    // R1: alternation from reset
    bad = 0;
    for (int k = 1; k < 64; k++) begin
      get_bit(b, s);
      if (b != ((k % 2) == 0)) bad++;
    end
    check(bad == 0, "R1", "alternation mismatches", bad, 0);

    // R6: divider timing
    @(posedge bclk) t0 = $time;
    @(negedge bclk) t1 = $time;
    @(posedge bclk) t2 = $time;
    check((t1 - t0) == HALF*CLK_P, "R6", "high time", real'(t1 - t0), HALF*CLK_P);
    check((t2 - t0) == 2*HALF*CLK_P, "R6", "period", real'(t2 - t0), 2*HALF*CLK_P);

    // R8: pulses on sample between rising edges are ignored
    do_reset();
    bad = 0;
    for (int k = 0; k < 64; k++) begin
      @(posedge bclk); #1;
      if (dout != ((k % 2) == 0)) bad++;
      #2 sample = 16'sd32767;
      #(2*HALF*CLK_P - 10) sample = '0;
    end
    check(bad == 0, "R8", "stream disturbed by mid-period pulses", bad, 0);

    density(0, "R1", 1'b0);
    density(25600, "R2", 1'b0);
    density(-25600, "R2", 1'b0);
    density(32767, "R3", 1'b1);
    density(-32768, "R3", 1'b1);
    density(0, "R9", 1'b0);
    density(-32767, "R3", 1'b1);
    for (int k = 0; k < 4; k++) begin
      int c = int'($urandom_range(56000, 0)) - 28000;
      density(c, "R4", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule